// File: doc/BRIEF.md
# Reference-Window Frequency Error Detector

This block measures how fast an oscillator clock runs compared with a slower reference clock. It counts the oscillator's rising edges between two consecutive rising edges of the reference clock. It then compares that count with a programmable target ratio and reports one of three outcomes. The oscillator is slow when the count is below the target, fast when the count is above it, and on frequency when the two are equal. A frequency-acquisition controller uses the result to decide which way to steer its oscillator.

All logic runs on the oscillator clock. The reference clock is treated as a plain asynchronous data input. It passes through a short synchronizer and an edge detector, and the resulting one-cycle tick both closes one counting window and opens the next. No separate retiming stage is used. One result is produced per reference period. It is marked by a one-cycle valid strobe and then held until the next result. The window that was open when reset was released is never reported.

Top module: `refwin_freq_det`

## Requirements
- R1: The reported count equals the number of oscillator rising edges from one synchronized reference rising edge to the next. A reference period of P oscillator cycles, with P in range, reports P.
- R2: The slow flag `slow_o` is 1 and the other two flags are 0 when the reported count is less than the target `target_i`.
- R3: The fast flag `fast_o` is 1 and the other two flags are 0 when the reported count is greater than the target.
- R4: The locked flag `locked_o` is 1 and the other two flags are 0 when the reported count equals the target.
- R5: At most one of the three flags is 1 at any time. After reset, all three stay 0 until the first result is reported.
- R6: `valid_o` is 1 for exactly one oscillator cycle per completed reference period. Count and flags change only in that cycle and hold their values in every other cycle.
- R7: The first reference rising edge after reset only starts a window and produces no result. A segment of K reference rising edges after reset yields K-1 results.
- R8: The count is 10 bits wide and saturates at 1023 instead of wrapping. A period longer than 1023 cycles reports 1023.
- R9: A synchronous active-high reset clears the count to 0, clears all flags and clears `valid_o`.
- R10: The target is sampled on the oscillator edge that closes the window. A change of target during a window affects only windows that close after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; every register of the block runs on it |
| rst | input | 1 | Synchronous active-high reset, in the oscillator domain |
| ref_clk | input | 1 | Reference clock, treated as an asynchronous input |
| target_i | input | 10 | Target number of oscillator cycles per reference period |
| count_o | output | 10 | Count captured for the last completed window |
| slow_o | output | 1 | Oscillator is slower than the target ratio |
| fast_o | output | 1 | Oscillator is faster than the target ratio |
| locked_o | output | 1 | Count matches the target exactly |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench checks windows whose length is one cycle either side of the target and exactly on it. An off-by-one in the counter would show up there as a wrong flag, usually slow in place of locked. It runs windows longer than 1023 cycles and windows of exactly 1023 and 1022 cycles. A wrapping counter would then report a small count and a false slow, and a wrong saturation limit would turn the expected lock into a slow result. Each segment after reset is checked for the number of results it produces. A design that reported the partial first window would give one extra result with a short count. The bench also watches every cycle between strobes, so outputs that drift or a strobe longer than one cycle would both be reported.

// File: rtl/fed_pkg.sv
package fed_pkg;
    localparam int CNT_W_DEF   = 10;
    localparam int SYNC_ST_DEF = 2;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_SLOW = 2'd1,
        ST_FAST = 2'd2,
        ST_LOCK = 2'd3
    } fed_status_e;
endpackage

// File: rtl/fed_edge_sync.sv
module fed_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES:0] chain;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
    assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fed_win_counter.sv
module fed_win_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    output logic         armed_o,
    output logic [W-1:0] win_count_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt;
    logic         armed;

    // edges since the last tick, including the closing edge
    assign win_count_o = (cnt == MAXV) ? MAXV : cnt + 1'b1;
    assign armed_o     = armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (tick_i) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else begin
            cnt   <= win_count_o;
        end
    end
endmodule

// File: rtl/fed_status_reg.sv
module fed_status_reg #(
    parameter int W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                armed_i,
    input  logic [W-1:0]        win_count_i,
    input  logic [W-1:0]        target_i,
    output logic [W-1:0]        count_o,
    output fed_pkg::fed_status_e status_o,
    output logic                valid_o
);
    import fed_pkg::*;

    fed_status_e verdict;

    always_comb begin
        if (win_count_i < target_i)      verdict = ST_SLOW;
        else if (win_count_i > target_i) verdict = ST_FAST;
        else                             verdict = ST_LOCK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o  <= '0;
            status_o <= ST_NONE;
            valid_o  <= 1'b0;
        end else if (tick_i && armed_i) begin
            count_o  <= win_count_i;
            status_o <= verdict;
            valid_o  <= 1'b1;
        end else begin
            valid_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/refwin_freq_det.sv
module refwin_freq_det #(
    parameter int CNT_W   = fed_pkg::CNT_W_DEF,
    parameter int SYNC_ST = fed_pkg::SYNC_ST_DEF
) (
    input  logic             osc_clk,
    input  logic             rst,
    input  logic             ref_clk,
    input  logic [CNT_W-1:0] target_i,
    output logic [CNT_W-1:0] count_o,
    output logic             slow_o,
    output logic             fast_o,
    output logic             locked_o,
    output logic             valid_o
);
    import fed_pkg::*;

    logic             tick;
    logic             armed;
    logic [CNT_W-1:0] win_count;
    fed_status_e      status;

    fed_edge_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk(osc_clk), .rst(rst), .async_in(ref_clk), .rise_o(tick)
    );

    fed_win_counter #(.W(CNT_W)) u_cnt (
        .clk(osc_clk), .rst(rst), .tick_i(tick),
        .armed_o(armed), .win_count_o(win_count)
    );

    fed_status_reg #(.W(CNT_W)) u_stat (
        .clk(osc_clk), .rst(rst), .tick_i(tick), .armed_i(armed),
        .win_count_i(win_count), .target_i(target_i),
        .count_o(count_o), .status_o(status), .valid_o(valid_o)
    );

    assign slow_o   = (status == ST_SLOW);
    assign fast_o   = (status == ST_FAST);
    assign locked_o = (status == ST_LOCK);
endmodule

// File: rtl/refwin_freq_det_chk.sv
module refwin_freq_det_chk #(
    parameter int CNT_W = 10
) (
    input logic             osc_clk,
    input logic             rst,
    input logic [CNT_W-1:0] target_i,
    input logic [CNT_W-1:0] count_o,
    input logic             slow_o,
    input logic             fast_o,
    input logic             locked_o,
    input logic             valid_o
);
    AST_SLOW_REL: assert property (@(posedge osc_clk) disable iff (rst)
        valid_o |-> (slow_o == (count_o < $past(target_i)))); // R2

    AST_FAST_REL: assert property (@(posedge osc_clk) disable iff (rst)
        valid_o |-> (fast_o == (count_o > $past(target_i)))); // R3

    AST_LOCK_REL: assert property (@(posedge osc_clk) disable iff (rst)
        valid_o |-> (locked_o == (count_o == $past(target_i)))); // R4

    AST_ONE_FLAG: assert property (@(posedge osc_clk) disable iff (rst)
        $countones({slow_o, fast_o, locked_o}) <= 1); // R5

    AST_FLAG_ON_RESULT: assert property (@(posedge osc_clk) disable iff (rst)
        valid_o |-> $countones({slow_o, fast_o, locked_o}) == 1); // R5

    AST_STROBE_SHORT: assert property (@(posedge osc_clk) disable iff (rst)
        valid_o |=> !valid_o); // R6

    AST_HOLD: assert property (@(posedge osc_clk) disable iff (rst)
        !valid_o |-> ($stable(count_o) && $stable({slow_o, fast_o, locked_o}))); // R6

    AST_RESET_CLEAR: assert property (@(posedge osc_clk)
        rst |=> (!valid_o && count_o == '0 && !slow_o && !fast_o && !locked_o)); // R9
endmodule

bind refwin_freq_det refwin_freq_det_chk #(.CNT_W(CNT_W)) u_chk (
    .osc_clk(osc_clk), .rst(rst), .target_i(target_i), .count_o(count_o),
    .slow_o(slow_o), .fast_o(fast_o), .locked_o(locked_o), .valid_o(valid_o)
);

// File: tb/refwin_freq_det_bench.sv
`timescale 1ns/1ps
module refwin_freq_det_bench;
    localparam int W = 10;

    logic         osc_clk = 1'b0;
    logic         rst = 1'b1;
    logic         ref_clk = 1'b0;
    logic [W-1:0] target = 10'd6;
    logic [W-1:0] count_o;
    logic         slow_o, fast_o, locked_o, valid_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int exp_p [0:255];
    int exp_t [0:255];
    int n_calls  = 0;
    int next_res = 0;
    int seg_res  = 0;
    int hold_err = 0;
    int strobe_err = 0;
    bit seen     = 0;
    bit prev_v   = 0;
    logic [W-1:0] last_cnt;
    logic [2:0]   last_flags;

    always #2.5 osc_clk = ~osc_clk;

    refwin_freq_det u_refwin_freq_det (
        .osc_clk(osc_clk), .rst(rst), .ref_clk(ref_clk), .target_i(target),
        .count_o(count_o), .slow_o(slow_o), .fast_o(fast_o),
        .locked_o(locked_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int sat_of(input int p);
        return (p > 1023) ? 1023 : p;
    endfunction

    function automatic logic [2:0] flags_of(input int c, input int t);
        if (c < t)      return 3'b100;
        else if (c > t) return 3'b010;
        else            return 3'b001;
    endfunction

    // monitor, sampling away from the active edge
    always @(negedge osc_clk) begin
        if (rst) begin
            prev_v = 0;
        end else begin
            if (valid_o) begin
                int c;
                c = sat_of(exp_p[next_res]);
                check(count_o == W'(c), (exp_p[next_res] > 1023) ? "R8 count" : "R1 count",
                      count_o, c);
                check({slow_o, fast_o, locked_o} == flags_of(c, exp_t[next_res]),
                      "R2/R3/R4 flags", {slow_o, fast_o, locked_o}, flags_of(c, exp_t[next_res]));
                if (prev_v) strobe_err++;
                next_res++;
                seg_res++;
                seen = 1;
                last_cnt = count_o;
                last_flags = {slow_o, fast_o, locked_o};
            end else if (seen) begin
                if (count_o != last_cnt || {slow_o, fast_o, locked_o} != last_flags)
                    hold_err++;
            end
            prev_v = valid_o;
        end
    end

    task automatic ref_period(input int p, input int t);
        exp_p[n_calls] = p;
        exp_t[n_calls] = t;
        n_calls++;
        @(negedge osc_clk) ref_clk = 1'b1;
        repeat (5) @(negedge osc_clk);
        target = W'(t);          // settles long before this window closes (R10)
        repeat (p/2 - 6) @(negedge osc_clk);
        ref_clk = 1'b0;
        repeat (p - p/2) @(negedge osc_clk);
    endtask

    task automatic start_segment();
        @(negedge osc_clk) rst = 1'b1;
        ref_clk = 1'b0;
        repeat (4) @(negedge osc_clk);
        check(count_o == 0 && valid_o == 0, "R9 reset clear", count_o, 0);
        check({slow_o, fast_o, locked_o} == 3'b000, "R9 flags clear",
              {slow_o, fast_o, locked_o}, 0);
        rst = 1'b0;
        next_res = n_calls;
        seg_res  = 0;
        seen     = 0;
    endtask

    initial begin
        int seg_start;
        void'($urandom(32'd4711));
        start_segment();
        seg_start = n_calls;
        ref_period(20, 6);
        check(seg_res == 0 && {slow_o, fast_o, locked_o} == 3'b000,
              "R7 first window dropped / R5 no status", seg_res, 0);
        // directed: around target, and a target change between windows (R10)
        ref_period(30, 30);   // lock R4
        ref_period(29, 30);   // slow R2
        ref_period(31, 30);   // fast R3
        ref_period(40, 12);
        ref_period(40, 60);
        for (int i = 0; i < 30; i++) begin
            int t, p;
            t = 12 + int'($urandom_range(0, 60));
            p = t + int'($urandom_range(0, 4)) - 2;
            ref_period(p, t);
        end
        ref_period(20, 20);
        repeat (8) @(negedge osc_clk);
        check(seg_res == n_calls - seg_start - 1, "R7 result count", seg_res,
              n_calls - seg_start - 1);

        // second segment: saturation boundaries
        start_segment();
        seg_start = n_calls;
        ref_period(1100, 1000);  // saturates, fast R8
        ref_period(1023, 1023);  // exactly max, lock
        ref_period(1022, 1023);  // slow
        ref_period(1500, 1023);  // saturated count equals target, lock
        ref_period(20, 20);
        repeat (8) @(negedge osc_clk);
        check(seg_res == n_calls - seg_start - 1, "R7 result count seg2", seg_res,
              n_calls - seg_start - 1);
        check(hold_err == 0, "R6 hold between strobes", hold_err, 0);
        check(strobe_err == 0, "R6 strobe one cycle", strobe_err, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule